// File: doc/BRIEF.md
# Pulse-Coded Loop Current Setter

This block holds the level of a DC loop current source. The level is commanded over one active-low pulse line. The block measures how long each low pulse lasts, counted in system clock cycles after a two-stage synchroniser. A long pulse returns the level to zero. A pulse of intermediate width raises the level by one step. A very short pulse is treated as noise and ignored.

The level comes out as a 5-bit binary code that feeds an external R/2R current DAC. Code 0 means no current and code 30 means full scale, so each code step is half of the full-scale range divided by 15. A hold input gates the step pulses. A polarity input is passed through to a reversal output that selects the current direction.

On the trailing edge of every accepted pulse, the block also samples a line-busy input. It drives an active-low busy indicator from that sample. A disable input forces the indicator off. All pins are plain control and status levels, so there is no streaming interface and no back-pressure.

Top module: `loop_current_setter`

## Requirements
- R1: After reset, `level` is 0, `busy_ind_n` is 1 and `pol_rev` is 0.
- R2: A low pulse on `cmd_n` that lasts at least MIN_CYCLES and fewer than CLEAR_CYCLES clock cycles, with `hold` low, raises `level` by one. The new value appears after the third rising clock edge that follows the return of `cmd_n` to high.
- R3: `level` never exceeds 30. A step pulse that arrives at 30 leaves it at 30.
- R4: A low pulse that lasts CLEAR_CYCLES cycles or longer sets `level` to 0, whatever the state of `hold`.
- R5: While `hold` is high, a step-width pulse leaves `level` unchanged.
- R6: A low pulse shorter than MIN_CYCLES cycles is ignored entirely. It leaves both `level` and the latched busy state unchanged.
- R7: On the trailing edge of every pulse that is not ignored, `busy_in` is latched. This includes step pulses that are blocked by `hold` or by saturation. A latched 1 drives `busy_ind_n` low and a latched 0 drives it high.
- R8: While `busy_dis` is high, `busy_ind_n` is high. The latched busy state is kept and shows again once `busy_dis` falls.
- R9: `pol_rev` follows `pol_in` two clock edges later.
- R10: `level` changes only in response to an accepted pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_n | input | 1 | Active-low command pulse line, asynchronous |
| hold | input | 1 | High blocks step pulses |
| busy_in | input | 1 | Line-busy sense, high when the line is in use |
| busy_dis | input | 1 | High forces the busy indicator off |
| pol_in | input | 1 | Requested current direction |
| level | output | 5 | Binary current code for the DAC, 0 to 30 |
| pol_rev | output | 1 | Current reversal drive |
| busy_ind_n | output | 1 | Active-low busy indicator |

## Verification
The bench sweeps the pulse width across every value from one cycle to past the clear threshold. The widths at MIN_CYCLES-1 and MIN_CYCLES catch an off-by-one in the glitch filter, which would count noise as a step or drop a valid step. The widths at CLEAR_CYCLES-1 and CLEAR_CYCLES catch a design that reads the boundary pulse as the wrong kind.

A run of step pulses well past 30 exposes a counter that wraps or runs to 31. Blocked and ignored pulses are each given a busy value that differs from the one already latched. This shows whether the latch samples on every accepted pulse and only on those. Toggling the disable line shows whether the latched state is lost when the indicator is masked.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_STEP  = 2'd1,
    PK_CLEAR = 2'd2
  } pulse_kind_t;
endpackage

// File: rtl/lcs_sync.sv
module lcs_sync #(
  parameter int          N        = 1,
  parameter logic [15:0] RST_BITS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st1 <= RST_BITS[i];
        st2 <= RST_BITS[i];
      end else begin
        st1 <= d[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/lcs_pulse_classifier.sv
module lcs_pulse_classifier
  import lcs_pkg::*;
#(
  parameter int MIN_CYCLES   = 4,
  parameter int CLEAR_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_s,
  output pulse_kind_t kind
);
  localparam int CW = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CW-1:0] CLR_L = CW'(CLEAR_CYCLES);
  localparam logic [CW-1:0] MIN_L = CW'(MIN_CYCLES);

  logic          line_d;
  logic [CW-1:0] low_cnt;
  logic          rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_d  <= 1'b1;
      low_cnt <= '0;
    end else begin
      line_d <= line_s;
      if (line_s)
        low_cnt <= '0;
      else if (low_cnt != CLR_L)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  assign rise = line_s && !line_d;

  always_comb begin
    kind = PK_NONE;
    if (rise) begin
      if (low_cnt >= CLR_L)      kind = PK_CLEAR;
      else if (low_cnt >= MIN_L) kind = PK_STEP;
    end
  end
endmodule

// File: rtl/lcs_level_counter.sv
module lcs_level_counter
  import lcs_pkg::*;
#(
  parameter int LEVEL_W   = 5,
  parameter int MAX_LEVEL = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pulse_kind_t        kind,
  input  logic               hold_s,
  output logic [LEVEL_W-1:0] level
);
  localparam logic [LEVEL_W-1:0] TOP = LEVEL_W'(MAX_LEVEL);

  always_ff @(posedge clk) begin
    if (!rst_n)
      level <= '0;
    else if (kind == PK_CLEAR)
      level <= '0;
    else if (kind == PK_STEP && !hold_s && level < TOP)
      level <= level + 1'b1;
  end
endmodule

// File: rtl/lcs_busy_latch.sv
module lcs_busy_latch
  import lcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  pulse_kind_t kind,
  input  logic        busy_s,
  input  logic        busy_dis,
  output logic        busy_ind_n
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_q <= 1'b0;
    else if (kind != PK_NONE)
      busy_q <= busy_s;
  end

  assign busy_ind_n = !(busy_q && !busy_dis);
endmodule

// File: rtl/loop_current_setter.sv
module loop_current_setter
  import lcs_pkg::*;
#(
  parameter int LEVEL_W      = 5,
  parameter int MAX_LEVEL    = 30,
  parameter int MIN_CYCLES   = 4,
  parameter int CLEAR_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_n,
  input  logic               hold,
  input  logic               busy_in,
  input  logic               pol_in,
  input  logic               busy_dis,
  output logic [LEVEL_W-1:0] level,
  output logic               pol_rev,
  output logic               busy_ind_n
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_v, syn_v;
  pulse_kind_t      evt_kind;

  assign raw_v = {pol_in, busy_in, hold, cmd_n};

  lcs_sync #(.N(NSYNC), .RST_BITS(16'h0001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
  );

  lcs_pulse_classifier #(
    .MIN_CYCLES(MIN_CYCLES), .CLEAR_CYCLES(CLEAR_CYCLES)
  ) u_class (
    .clk(clk), .rst_n(rst_n), .line_s(syn_v[0]), .kind(evt_kind)
  );

  lcs_level_counter #(.LEVEL_W(LEVEL_W), .MAX_LEVEL(MAX_LEVEL)) u_level (
    .clk(clk), .rst_n(rst_n), .kind(evt_kind), .hold_s(syn_v[1]), .level(level)
  );

  lcs_busy_latch u_busy (
    .clk(clk), .rst_n(rst_n), .kind(evt_kind), .busy_s(syn_v[2]),
    .busy_dis(busy_dis), .busy_ind_n(busy_ind_n)
  );

  assign pol_rev = syn_v[3];
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker
  import lcs_pkg::*;
#(
  parameter int LEVEL_W   = 5,
  parameter int MAX_LEVEL = 30
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LEVEL_W-1:0] level,
  input pulse_kind_t        evt_kind,
  input logic [3:0]         syn_v,
  input logic               pol_in,
  input logic               pol_rev
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LEVEL_W'(MAX_LEVEL));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    evt_kind == PK_CLEAR |=> level == '0);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_kind == PK_STEP && !syn_v[1] && level < LEVEL_W'(MAX_LEVEL))
      |=> level == $past(level) + 1'b1);

  a_r5_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_kind == PK_STEP && syn_v[1]) |=> $stable(level));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    evt_kind == PK_NONE |=> $stable(level));

  a_r9_pol_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_in) |=> ##1 pol_rev);
endmodule

bind loop_current_setter lcs_checker #(.LEVEL_W(LEVEL_W), .MAX_LEVEL(MAX_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .level(level), .evt_kind(evt_kind),
  .syn_v(syn_v), .pol_in(pol_in), .pol_rev(pol_rev)
);

// File: tb/tb_loop_current_setter.sv
module tb_loop_current_setter;
  localparam int MINC = 3;
  localparam int CLRC = 20;
  localparam int TOPL = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_n = 1'b1, hold = 1'b0, busy_in = 1'b0, pol_in = 1'b0, busy_dis = 1'b0;
  logic [4:0] level;
  logic pol_rev, busy_ind_n;

  int checks = 0;
  int failures = 0;
  int exp_level = 0;
  int exp_busy = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  loop_current_setter #(.MIN_CYCLES(MINC), .CLEAR_CYCLES(CLRC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .hold(hold), .busy_in(busy_in),
    .pol_in(pol_in), .busy_dis(busy_dis), .level(level), .pol_rev(pol_rev),
    .busy_ind_n(busy_ind_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int w, input bit h, input bit b);
    @(negedge clk);
    hold = h;
    busy_in = b;
    repeat (3) @(negedge clk);
    cmd_n = 1'b0;
    repeat (w) @(negedge clk);
    cmd_n = 1'b1;
    repeat (4) @(negedge clk);
    if (w >= CLRC) begin
      exp_level = 0;
      exp_busy = b;
    end else if (w >= MINC) begin
      if (!h && exp_level < TOPL) exp_level++;
      exp_busy = b;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 level", level, 0);
    chk("R1 busy_ind_n", busy_ind_n, 1);
    chk("R1 pol_rev", pol_rev, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 R4 R6 R7: width sweep across both thresholds
    for (int w = 1; w <= CLRC + 4; w++) begin
      pulse(w, 1'b0, (w % 2) == 1);
      chk(w < MINC ? "R6 level" : (w >= CLRC ? "R4 level" : "R2 level"), level, exp_level);
      chk(w < MINC ? "R6 busy" : "R7 busy", busy_ind_n, exp_busy ? 0 : 1);
    end
    // R3: saturation
    for (int i = 1; i <= TOPL + 4; i++) begin
      pulse(MINC + (i % 5), 1'b0, (i % 3) == 0);
      chk("R3 level", level, exp_level);
      chk("R7 busy", busy_ind_n, exp_busy ? 0 : 1);
    end
    chk("R3 top", level, TOPL);
    // R5: hold blocks steps, latch still updates
    pulse(CLRC + 2, 1'b0, 1'b0);
    chk("R4 level", level, 0);
    for (int i = 0; i < 3; i++) begin
      pulse(MINC + 2, 1'b1, (i % 2) == 0);
      chk("R5 level", level, 0);
      chk("R7 busy", busy_ind_n, exp_busy ? 0 : 1);
    end
    pulse(MINC, 1'b0, 1'b1);
    chk("R2 level", level, 1);
    pulse(CLRC, 1'b1, 1'b1);
    chk("R4 hold level", level, 0);
    // R6: glitch with a different busy value
    pulse(MINC - 1, 1'b0, 1'b0);
    chk("R6 busy kept", busy_ind_n, 0);
    chk("R6 level", level, 0);
    // R8: disable masks, latch retained
    @(negedge clk);
    busy_dis = 1'b1;
    #1;
    chk("R8 masked", busy_ind_n, 1);
    @(negedge clk);
    busy_dis = 1'b0;
    #1;
    chk("R8 restored", busy_ind_n, 0);
    // R9: polarity pass-through
    @(negedge clk);
    pol_in = 1'b1;
    @(negedge clk);
    chk("R9 early", pol_rev, 0);
    @(negedge clk);
    chk("R9 set", pol_rev, 1);
    pol_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 clr", pol_rev, 0);
    // R10: no pulses, level steady
    pulse(MINC + 1, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    chk("R10 steady", level, 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule